// File: doc/BRIEF.md
# Audio Preamplifier Control Register Slave

This block is the two-wire serial control port of a stereo audio preamplifier. It sits on an I2C bus as a receive-only slave, with SCL and SDA sampled by a faster system clock. It recognises start and stop conditions and accepts only its own device address. It takes a subaddress byte that picks one of eight control registers, then loads the data bytes that follow into consecutive registers. It acknowledges every byte it accepts by pulling SDA low.

All eight registers drive the analog side in parallel: volume with loudness, four per-output fader attenuators, bass, treble, and a switch register that carries the general mute bit and the source select. Each write to the switch register also raises a one-cycle strobe. The mute logic uses this strobe to restart its zero-crossing timeout. A synchronous power-on reset loads the defaults, in which general mute is on.

Top module: `preamp_ctl_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0x80 (7-bit address 0x40 with the write bit 0). Any other address byte, including 0x81, is not acknowledged, and every byte up to the next start condition is ignored.
- R2: Only bits 2..0 of the subaddress byte are decoded. Index 0 selects volume, 1 front-right fader, 2 front-left fader, 3 rear-right fader, 4 rear-left fader, 5 bass, 6 treble and 7 switch. Bits 7..3 have no effect.
- R3: After each data byte the register index increments, wrapping from 7 to 0, so one transfer of nine data bytes starting at index 7 writes switch, then registers 0 to 7.
- R4: Stored bits: volume keeps all of bits 7..0 (bit 7 zero-crossing mode, bit 6 loudness off, bits 5..0 level). The faders keep bits 5..0. Bass and treble keep bits 4..0. Switch keeps bit 7 (general mute) and bits 2..0 (source). Every other bit reads as 0.
- R5: Reset clears every register to 0, except switch, which becomes 0x80 (general mute on). Reset also returns the receiver to idle, with SDA released.
- R6: `switch_wr_stb` is high for exactly one clock for each data byte written to index 7, and never for writes to other registers.
- R7: A data byte is written only after its eighth bit has been clocked in. A stop or a start condition that arrives before the eighth bit discards the partial byte.
- R8: For an accepted byte, `sda_oe` goes high while SCL is low after the eighth clock pulse, stays high through the ninth pulse, and is released once SCL falls after the ninth pulse.
- R9: A repeated start in any phase restarts the transfer at the address byte.
- R10: The registers hold their values when no data byte is committed, including across stops and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst | input | 1 | Synchronous active-high power-on reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| volume_q | output | 8 | Volume, loudness-off and zero-crossing mode |
| front_right_q | output | 8 | Front-right attenuator code |
| front_left_q | output | 8 | Front-left attenuator code |
| rear_right_q | output | 8 | Rear-right attenuator code |
| rear_left_q | output | 8 | Rear-left attenuator code |
| bass_q | output | 8 | Bass code |
| treble_q | output | 8 | Treble code |
| switch_q | output | 8 | General mute (bit 7) and source select (bits 2..0) |
| switch_wr_stb | output | 1 | One-cycle pulse on each switch write |

## Verification
The commit of a switch-register byte and the wrap of the register index from 7 back to 0 happen on the same SCL edge. The strobe then fires while the next byte is being aimed at register 0. The bench starts write bursts at every index with nine data bytes, so each burst crosses the wrap. It judges the result by the final values of all eight registers and by an exact count of strobe pulses. Abort cases place a stop or a repeated start in the middle of a byte headed for the switch and bass registers. They confirm that neither a write nor a strobe comes out.

// File: rtl/preamp_ctl_pkg.sv
package preamp_ctl_pkg;

    localparam int REG_COUNT   = 8;
    localparam int PTR_W       = $clog2(REG_COUNT);
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int BIT_CNT_W   = $clog2(DATA_W + 1);
    localparam int MUTE_BIT    = DATA_W - 1;

    localparam logic [6:0] DEV_ADDR = 7'h40;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    localparam ptr_t SWITCH_IDX = ptr_t'(REG_COUNT - 1);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_SUB,
        RX_DATA,
        RX_SKIP
    } rx_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic  en;
        ptr_t  idx;
        byte_t data;
    } wr_req_t;

    function automatic byte_t field_mask(ptr_t idx);
        byte_t m;
        if (idx == ptr_t'(0))
            m = 8'hFF;
        else if (idx <= ptr_t'(4))
            m = 8'h3F;
        else if (idx <= ptr_t'(6))
            m = 8'h1F;
        else
            m = 8'h87;
        return m;
    endfunction

    function automatic byte_t reset_value(ptr_t idx);
        byte_t v;
        v = '0;
        if (idx == SWITCH_IDX)
            v[MUTE_BIT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import preamp_ctl_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        evt.scl      = scl_now;
        evt.sda      = sda_now;
        evt.scl_rise = scl_now & ~scl_prev;
        evt.scl_fall = ~scl_now & scl_prev;
        evt.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        evt.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
    import preamp_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     sda_oe,
    output wr_req_t  wr
);

    rx_state_e            state;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [DATA_W-2:0]    shift;
    logic                 ack_pend;
    logic                 in_ack;
    ptr_t                 ptr;
    byte_t                rx_byte;
    logic                 active;
    logic                 last_bit;

    assign rx_byte  = {shift, evt.sda};
    assign active   = (state == RX_ADDR) || (state == RX_SUB) || (state == RX_DATA);
    assign last_bit = (bit_cnt == BIT_CNT_W'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            bit_cnt  <= '0;
            shift    <= '0;
            ack_pend <= 1'b0;
            in_ack   <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.stop) begin
                state    <= RX_IDLE;
                bit_cnt  <= '0;
                ack_pend <= 1'b0;
                in_ack   <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (evt.start) begin
                state    <= RX_ADDR;
                bit_cnt  <= '0;
                ack_pend <= 1'b0;
                in_ack   <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (active) begin
                if (evt.scl_rise) begin
                    if (bit_cnt == BIT_CNT_W'(DATA_W)) begin
                        in_ack <= 1'b1;
                    end else begin
                        shift   <= rx_byte[DATA_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            case (state)
                                RX_ADDR: begin
                                    if (rx_byte == {DEV_ADDR, 1'b0}) begin
                                        ack_pend <= 1'b1;
                                        state    <= RX_SUB;
                                    end else begin
                                        state    <= RX_SKIP;
                                    end
                                end
                                RX_SUB: begin
                                    ptr      <= rx_byte[PTR_W-1:0];
                                    ack_pend <= 1'b1;
                                    state    <= RX_DATA;
                                end
                                default: begin
                                    wr.en    <= 1'b1;
                                    wr.idx   <= ptr;
                                    wr.data  <= rx_byte;
                                    ptr      <= ptr + 1'b1;
                                    ack_pend <= 1'b1;
                                end
                            endcase
                        end
                    end
                end else if (evt.scl_fall) begin
                    if (in_ack) begin
                        sda_oe  <= 1'b0;
                        in_ack  <= 1'b0;
                        bit_cnt <= '0;
                    end else if (ack_pend) begin
                        sda_oe   <= 1'b1;
                        ack_pend <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import preamp_ctl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  wr_req_t                            wr,
    output logic [REG_COUNT-1:0][DATA_W-1:0]   regs_q,
    output logic                               switch_stb
);

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        localparam ptr_t IDX = ptr_t'(i);
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= reset_value(IDX);
            else if (wr.en && wr.idx == IDX)
                regs_q[i] <= wr.data & field_mask(IDX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            switch_stb <= 1'b0;
        else
            switch_stb <= wr.en && (wr.idx == SWITCH_IDX);
    end

endmodule

// File: rtl/preamp_ctl_slave.sv
module preamp_ctl_slave
    import preamp_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] volume_q,
    output logic [7:0] front_right_q,
    output logic [7:0] front_left_q,
    output logic [7:0] rear_right_q,
    output logic [7:0] rear_left_q,
    output logic [7:0] bass_q,
    output logic [7:0] treble_q,
    output logic [7:0] switch_q,
    output logic       switch_wr_stb
);

    bus_evt_t                           evt;
    wr_req_t                            wr_req;
    logic [REG_COUNT-1:0][DATA_W-1:0]   regs;
    logic                               scl_seen;
    logic                               wr_en;
    ptr_t                               wr_idx;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_byte_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .sda_oe (sda_oe),
        .wr     (wr_req)
    );

    ctl_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_req),
        .regs_q     (regs),
        .switch_stb (switch_wr_stb)
    );

    assign scl_seen = evt.scl;
    assign wr_en    = wr_req.en;
    assign wr_idx   = wr_req.idx;

    assign volume_q      = regs[0];
    assign front_right_q = regs[1];
    assign front_left_q  = regs[2];
    assign rear_right_q  = regs[3];
    assign rear_left_q   = regs[4];
    assign bass_q        = regs[5];
    assign treble_q      = regs[6];
    assign switch_q      = regs[7];

endmodule

// File: rtl/preamp_ctl_checker.sv
module preamp_ctl_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_seen,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [2:0] wr_idx,
    input logic [7:0] volume_q,
    input logic [7:0] front_right_q,
    input logic [7:0] front_left_q,
    input logic [7:0] rear_right_q,
    input logic [7:0] rear_left_q,
    input logic [7:0] bass_q,
    input logic [7:0] treble_q,
    input logic [7:0] switch_q,
    input logic       switch_wr_stb
);

    assert_reset_default_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (switch_q == 8'h80 && volume_q == 8'h00 && bass_q == 8'h00 && !sda_oe));

    assert_ack_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_seen);

    assert_strobe_source_R6: assert property (@(posedge clk) disable iff (rst)
        switch_wr_stb |-> ($past(wr_en) && $past(wr_idx) == 3'd7));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        switch_wr_stb |=> !switch_wr_stb);

    assert_unused_bits_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (front_right_q[7:6] == 2'b00 && front_left_q[7:6] == 2'b00 &&
         rear_right_q[7:6] == 2'b00 && rear_left_q[7:6] == 2'b00 &&
         bass_q[7:5] == 3'b000 && treble_q[7:5] == 3'b000 && switch_q[6:3] == 4'b0000));

    assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(volume_q) && $stable(front_right_q) && $stable(front_left_q) &&
                    $stable(rear_right_q) && $stable(rear_left_q) && $stable(bass_q) &&
                    $stable(treble_q) && $stable(switch_q)));

endmodule

bind preamp_ctl_slave preamp_ctl_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_seen      (scl_seen),
    .sda_oe        (sda_oe),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .volume_q      (volume_q),
    .front_right_q (front_right_q),
    .front_left_q  (front_left_q),
    .rear_right_q  (rear_right_q),
    .rear_left_q   (rear_left_q),
    .bass_q        (bass_q),
    .treble_q      (treble_q),
    .switch_q      (switch_q),
    .switch_wr_stb (switch_wr_stb)
);

// File: tb/preamp_ctl_slave_test.sv
`timescale 1ns/1ps
module preamp_ctl_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [7:0] volume_q, front_right_q, front_left_q, rear_right_q, rear_left_q;
    logic [7:0] bass_q, treble_q, switch_q;
    logic switch_wr_stb;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    int exp_stb = 0;
    bit finished = 0;
    logic [7:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    preamp_ctl_slave uut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .volume_q      (volume_q),
        .front_right_q (front_right_q),
        .front_left_q  (front_left_q),
        .rear_right_q  (rear_right_q),
        .rear_left_q   (rear_left_q),
        .bass_q        (bass_q),
        .treble_q      (treble_q),
        .switch_q      (switch_q),
        .switch_wr_stb (switch_wr_stb)
    );

    always @(negedge clk) if (!rst && switch_wr_stb) stb_cnt++;

    function automatic logic [7:0] mask_of(int i);
        if (i == 0) return 8'hFF;
        if (i <= 4) return 8'h3F;
        if (i <= 6) return 8'h1F;
        return 8'h87;
    endfunction

    function automatic logic [7:0] reg_out(int i);
        case (i)
            0: return volume_q;
            1: return front_right_q;
            2: return front_left_q;
            3: return rear_right_q;
            4: return rear_left_q;
            5: return bass_q;
            6: return treble_q;
            default: return switch_q;
        endcase
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < 8; i++) check(req, reg_out(i), model[i]);
    endtask

    task automatic wait_q(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        model[7] = 8'h80;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        scl_m = 1'b1;
        sda_m = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b0; wait_q(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(1);
        scl_m = 1'b1; wait_q(1);
        sda_m = 1'b1; wait_q(2);
    endtask

    task automatic send_bits(logic [7:0] value, int n);
        for (int b = 7; b > 7 - n; b--) begin
            sda_m = value[b]; wait_q(1);
            scl_m = 1'b1; wait_q(2);
            scl_m = 1'b0; wait_q(1);
        end
    endtask

    task automatic send_byte(logic [7:0] value, output bit acked, output bit released);
        bit early;
        bit held;
        send_bits(value, 8);
        sda_m = 1'b1;
        early = (sda_line == 1'b0);
        scl_m = 1'b1; wait_q(1);
        held = (sda_line == 1'b0);
        wait_q(1);
        scl_m = 1'b0; wait_q(1);
        released = (sda_line == 1'b1);
        acked = early && held;
    endtask

    task automatic write_burst(int start_idx, logic [7:0] sub_byte, int count, int seed);
        bit a, r;
        logic [7:0] d;
        bus_start();
        send_byte(8'h80, a, r);
        check("R1 address ack", a, 1);
        send_byte(sub_byte, a, r);
        check("R8 subaddress ack", a, 1);
        check("R8 release after ninth pulse", r, 1);
        for (int k = 0; k < count; k++) begin
            int idx;
            d = 8'((seed * 53 + k * 29 + 7) & 255);
            idx = (start_idx + k) % 8;
            send_byte(d, a, r);
            check("R8 data ack", a, 1);
            model[idx] = d & mask_of(idx);
            if (idx == 7) exp_stb++;
        end
        bus_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit a, r;
        do_reset();
        // R5: defaults after reset
        check_regs("R5 reset defaults");
        check("R5 sda released", sda_oe, 0);

        // R2 R3 R4 R6: bursts from every index with noisy upper subaddress bits, crossing the wrap
        for (int p = 0; p < 8; p++) begin
            logic [7:0] sub;
            sub = {5'((p * 37 + 11) & 31), 3'(p)};
            write_burst(p, sub, 9, p);
            check_regs("R3 R4 burst from each index");
            check("R6 strobe count", stb_cnt, exp_stb);
        end
        // R2: subaddress upper bits ignored, single write
        write_burst(5, 8'hFD, 1, 99);
        check("R2 upper subaddress bits ignored", bass_q, model[5]);
        check("R6 no strobe for bass", stb_cnt, exp_stb);

        // R1: foreign address and read bit are not acknowledged, rest ignored
        bus_start();
        send_byte(8'h82, a, r);
        check("R1 nack other address", a, 0);
        send_byte(8'h07, a, r);
        send_byte(8'h05, a, r);
        check("R1 bytes after nack not acked", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'h81, a, r);
        check("R1 nack read bit", a, 0);
        send_byte(8'h00, a, r);
        send_byte(8'h3C, a, r);
        bus_stop();
        check_regs("R1 registers untouched after nack");
        check("R6 no strobe after nack", stb_cnt, exp_stb);

        // R7: stop in mid-byte toward the switch register
        bus_start();
        send_byte(8'h80, a, r);
        send_byte(8'h06, a, r);
        send_byte(8'h15, a, r);
        model[6] = 8'h15 & mask_of(6);
        send_bits(8'h03, 5);
        bus_stop();
        check("R7 treble written", treble_q, model[6]);
        check("R7 switch unchanged by partial byte", switch_q, model[7]);
        check("R7 no strobe for partial byte", stb_cnt, exp_stb);

        // R9: repeated start in mid-byte, then new transfer
        bus_start();
        send_byte(8'h80, a, r);
        send_byte(8'h05, a, r);
        send_bits(8'hE0, 3);
        bus_rstart();
        send_byte(8'h80, a, r);
        check("R9 address ack after repeated start", a, 1);
        send_byte(8'h00, a, r);
        send_byte(8'hA5, a, r);
        model[0] = 8'hA5;
        bus_stop();
        check("R7 bass unchanged by aborted byte", bass_q, model[5]);
        check("R9 volume written after repeated start", volume_q, model[0]);

        // R10: idle bus leaves registers alone
        wait_q(20);
        check_regs("R10 hold while idle");
        check("R10 sda released at idle", sda_oe, 0);

        // R5: reset after activity
        do_reset();
        check_regs("R5 defaults after second reset");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule